// File: doc/BRIEF.md
# Timer Register Access Guard

This block is the bus-facing control and status front end of a seconds and sub-seconds counter that advances on a slow timer tick. It holds the counter's control word, its two count registers and two alarm registers. It decides which software writes are allowed to land.

Updates that need the next slow tick to settle raise a busy flag. Until that tick arrives, later writes to the same controls are dropped. A ready flag marks the window in which the count values are stable. It falls on a pre-ripple warning and rises again when the counter ripples. An optional level interrupt follows it.

The counter's ripple is a tick pulse that arrives while the counter runs. Software uses a simple write port and a combinational read port. A write that is refused gives no response and changes nothing. Alarm comparison and clock-domain crossing are not part of this block.

Top module: `timer_access_guard`

## Requirements
- R1: Reset (`rst_n` low, released through a two-stage synchronizer) sets the control word to 0x10, with only busy set. It also clears both counts and both alarm registers, and holds `irq` low.
- R2: Busy is set by an accepted seconds write or by an accepted change to the run bit or to either alarm-enable bit. It clears at the next `tick`. If a setting event and a tick fall in the same cycle, busy stays set.
- R3: While busy is set, writes to the run bit, to both alarm-enable bits and to both count registers are dropped.
- R4: Software can clear the run bit only while unlock is 1 and busy is 0. Software can set it whenever busy is 0.
- R5: The seconds register (address 1) and the sub-seconds register (address 2) accept writes only while run is 0 and busy is 0. A sub-seconds write does not set busy.
- R6: A `tick` while run is 1 is a ripple. On a ripple the sub-seconds count (SUB_W bits) increments. When it wraps from all ones, the seconds count also increments. A `tick` while run is 0 leaves both counts unchanged.
- R7: A `pre_ripple` pulse clears ready, and a ripple sets ready.
- R8: Writing 0 to the ready bit clears it. Writing 1 to the ready bit has no effect. The busy bit is read-only.
- R9: When a ripple and a clear of ready (by software or by `pre_ripple`) fall in the same cycle, ready ends up set.
- R10: `irq` is a level that is high whenever ready and the ready-interrupt enable are both 1.
- R11: The time-of-day alarm register (address 3) accepts writes only while its enable is 0. The sub-second alarm register (address 4) accepts writes only while its own enable is 0. Both alarm registers can be read at any time.
- R12: The control word is at address 0. Its bits are: run (bit 0), unlock (bit 1), time-of-day alarm enable (bit 2), sub-second alarm enable (bit 3), busy (bit 4), ready (bit 5) and ready-interrupt enable (bit 6). Unlock and the interrupt enable take every control write, even while busy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | DATA_W | Read data (combinational) |
| tick | input | 1 | One-cycle slow timer tick |
| pre_ripple | input | 1 | One-cycle warning before a counter ripple |
| irq | output | 1 | Ready interrupt level |

## Verification
A wrong busy or ready state shows up at the ports on the next clock edge. The control word read back at address 0 shows the flag directly, and dropped or accepted writes show up as the count or alarm values read back one cycle later. A lost tick commit leaves busy stuck high. Every following control or count write is then refused, so the first write attempted after that tick already reads back wrong. A faulty ripple path shows up in the sub-seconds count at the first tick, and at the wrap in the seconds count.

// File: rtl/tag_pkg.sv
package tag_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTRL_W = 7;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_SEC  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_SUB  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_TOD  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_SSA  = 3'd4;

  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_UNLOCK = 1;
  localparam int unsigned B_TOD_EN = 2;
  localparam int unsigned B_SS_EN  = 3;
  localparam int unsigned B_BUSY   = 4;
  localparam int unsigned B_READY  = 5;
  localparam int unsigned B_IRQ_EN = 6;

  // packed MSB first: field order matches bit positions 6..0
  typedef struct packed {
    logic irq_en;
    logic ready;
    logic busy;
    logic ss_en;
    logic tod_en;
    logic unlock;
    logic run;
  } ctrl_t;

endpackage

// File: rtl/tag_rst_sync.sv
module tag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/tag_ctrl_reg.sv
module tag_ctrl_reg
  import tag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              sec_wr_ok,
  input  logic              tick,
  input  logic              pre_ripple,
  output ctrl_t             ctrl_q,
  output logic              ripple,
  output logic              cnt_wr_ok,
  output logic              irq
);

  ctrl_t ctrl_d;
  logic  ctrl_ce;
  logic  sw_clr_ready;
  logic  en_changed;

  assign ripple    = tick & ctrl_q.run;
  assign cnt_wr_ok = ~ctrl_q.run & ~ctrl_q.busy;
  assign ctrl_ce   = ctrl_wr | tick | pre_ripple | sec_wr_ok;

  always_comb begin
    ctrl_d       = ctrl_q;
    sw_clr_ready = 1'b0;
    if (ctrl_wr) begin
      ctrl_d.unlock = ctrl_wdata[B_UNLOCK];
      ctrl_d.irq_en = ctrl_wdata[B_IRQ_EN];
      sw_clr_ready  = ~ctrl_wdata[B_READY];
      if (!ctrl_q.busy) begin
        if (ctrl_wdata[B_RUN] && !ctrl_q.run) begin
          ctrl_d.run = 1'b1;
        end else if (!ctrl_wdata[B_RUN] && ctrl_q.run && ctrl_q.unlock) begin
          ctrl_d.run = 1'b0;
        end
        ctrl_d.tod_en = ctrl_wdata[B_TOD_EN];
        ctrl_d.ss_en  = ctrl_wdata[B_SS_EN];
      end
    end
    en_changed = (ctrl_d.run != ctrl_q.run) |
                 (ctrl_d.tod_en != ctrl_q.tod_en) |
                 (ctrl_d.ss_en != ctrl_q.ss_en);
    if (en_changed || sec_wr_ok) begin
      ctrl_d.busy = 1'b1;
    end else if (tick) begin
      ctrl_d.busy = 1'b0;
    end
    if (ripple) begin
      ctrl_d.ready = 1'b1;
    end else if (pre_ripple || sw_clr_ready) begin
      ctrl_d.ready = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{busy: 1'b1, default: 1'b0};
    end else if (ctrl_ce) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign irq = ctrl_q.ready & ctrl_q.irq_en;

  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr_ok |=> ctrl_q.busy);
  // R2
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_wr && !sec_wr_ok) |=> !ctrl_q.busy);
  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.busy |=> (ctrl_q.run == $past(ctrl_q.run)) &&
                    (ctrl_q.tod_en == $past(ctrl_q.tod_en)) &&
                    (ctrl_q.ss_en == $past(ctrl_q.ss_en)));
  // R4
  run_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.run && !ctrl_q.unlock) |=> ctrl_q.run);
  // R7
  pre_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_ripple && !ripple) |=> !ctrl_q.ready);
  // R8
  ready_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.ready) |-> $past(ripple));
  // R8
  busy_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.busy) |-> ($past(sec_wr_ok) || $past(ctrl_wr)));
  // R9
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ripple |=> ctrl_q.ready);
  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ripple) || $past(ctrl_wr)));

endmodule

// File: rtl/tag_count.sv
module tag_count #(
  parameter int unsigned SEC_W = 32,
  parameter int unsigned SUB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ripple,
  input  logic             sec_wr,
  input  logic             sub_wr,
  input  logic [SEC_W-1:0] sec_wdata,
  input  logic [SUB_W-1:0] sub_wdata,
  output logic [SEC_W-1:0] sec_q,
  output logic [SUB_W-1:0] sub_q
);

  logic [SEC_W-1:0] sec_d;
  logic [SUB_W-1:0] sub_d;
  logic             sec_ce;
  logic             sub_ce;
  logic             sub_wrap;

  assign sub_wrap = &sub_q;
  assign sub_ce   = ripple | sub_wr;
  assign sec_ce   = (ripple & sub_wrap) | sec_wr;

  always_comb begin
    sub_d = sub_wdata;
    sec_d = sec_wdata;
    if (ripple) begin
      sub_d = sub_q + 1'b1;
      sec_d = sec_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (sub_ce) begin
      sub_q <= sub_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (sec_ce) begin
      sec_q <= sec_d;
    end
  end

  // R6
  sub_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ripple |=> sub_q == $past(sub_q) + 1'b1);
  // R6
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ripple && sub_wrap) |=> sec_q == $past(sec_q) + 1'b1);
  // R6
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ripple && !sub_wrap) |=> $stable(sec_q));

endmodule

// File: rtl/tag_guarded_reg.sv
module tag_guarded_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic         lock,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic ce;

  assign ce = wr & ~lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (ce) begin
      q <= d;
    end
  end

  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(q));

endmodule

// File: rtl/timer_access_guard.sv
module timer_access_guard #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned SUB_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tick,
  input  logic              pre_ripple,
  output logic              irq
);
  import tag_pkg::*;

  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned NUM_ALARM   = 2;

  logic             rst_core_n;
  ctrl_t            ctrl_q;
  logic             ripple;
  logic             cnt_wr_ok;
  logic             ctrl_wr;
  logic             sec_wr_ok;
  logic             sub_wr_ok;
  logic [SEC_W-1:0] sec_q;
  logic [SUB_W-1:0] sub_q;
  logic [SEC_W-1:0] tod_alarm_q;
  logic [SUB_W-1:0] ss_alarm_q;

  tag_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign ctrl_wr   = wr_en & (wr_addr == ADR_CTRL);
  assign sec_wr_ok = wr_en & (wr_addr == ADR_SEC) & cnt_wr_ok;
  assign sub_wr_ok = wr_en & (wr_addr == ADR_SUB) & cnt_wr_ok;

  tag_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (wr_data[CTRL_W-1:0]),
    .sec_wr_ok  (sec_wr_ok),
    .tick       (tick),
    .pre_ripple (pre_ripple),
    .ctrl_q     (ctrl_q),
    .ripple     (ripple),
    .cnt_wr_ok  (cnt_wr_ok),
    .irq        (irq)
  );

  tag_count #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ripple    (ripple),
    .sec_wr    (sec_wr_ok),
    .sub_wr    (sub_wr_ok),
    .sec_wdata (wr_data[SEC_W-1:0]),
    .sub_wdata (wr_data[SUB_W-1:0]),
    .sec_q     (sec_q),
    .sub_q     (sub_q)
  );

  // one guarded register per alarm: index 0 time-of-day, index 1 sub-second
  for (genvar g = 0; g < NUM_ALARM; g++) begin : g_alarm
    if (g == 0) begin : g_tod
      tag_guarded_reg #(.W(SEC_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_core_n),
        .wr    (wr_en & (wr_addr == ADR_TOD)),
        .lock  (ctrl_q.tod_en),
        .d     (wr_data[SEC_W-1:0]),
        .q     (tod_alarm_q)
      );
    end else begin : g_ss
      tag_guarded_reg #(.W(SUB_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_core_n),
        .wr    (wr_en & (wr_addr == ADR_SSA)),
        .lock  (ctrl_q.ss_en),
        .d     (wr_data[SUB_W-1:0]),
        .q     (ss_alarm_q)
      );
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADR_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
      ADR_SEC:  rd_data[SEC_W-1:0]  = sec_q;
      ADR_SUB:  rd_data[SUB_W-1:0]  = sub_q;
      ADR_TOD:  rd_data[SEC_W-1:0]  = tod_alarm_q;
      ADR_SSA:  rd_data[SUB_W-1:0]  = ss_alarm_q;
      default:  rd_data = '0;
    endcase
  end

  // R5
  cnt_lock_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && (wr_addr == ADR_SEC) && (ctrl_q.run || ctrl_q.busy) && !ripple)
      |=> $stable(sec_q));
  // R5
  sub_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sub_wr_ok && !ctrl_q.busy) |=> !ctrl_q.busy);

endmodule

// File: tb/test_timer_access_guard.sv
module test_timer_access_guard;

  localparam logic [1:0] OP_W = 2'd0;
  localparam logic [1:0] OP_T = 2'd1;
  localparam logic [1:0] OP_P = 2'd2;
  localparam logic [1:0] OP_I = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [2:0]  cadr;
    logic [31:0] exp;
    logic [23:0] tag;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{OP_W, 3'd0, 32'h01,       3'd0, 32'h10,       "R3"},
    '{OP_W, 3'd1, 32'h05,       3'd1, 32'h0,        "R3"},
    '{OP_T, 3'd0, 32'h0,        3'd0, 32'h00,       "R2"},
    '{OP_I, 3'd0, 32'h0,        3'd2, 32'h0,        "R6"},
    '{OP_W, 3'd1, 32'h100,      3'd1, 32'h100,      "R5"},
    '{OP_I, 3'd0, 32'h0,        3'd0, 32'h10,       "R2"},
    '{OP_W, 3'd2, 32'hFE,       3'd2, 32'h0,        "R3"},
    '{OP_T, 3'd0, 32'h0,        3'd0, 32'h00,       "R2"},
    '{OP_W, 3'd2, 32'hFE,       3'd2, 32'hFE,       "R5"},
    '{OP_I, 3'd0, 32'h0,        3'd0, 32'h00,       "R5"},
    '{OP_W, 3'd3, 32'hAAAA,     3'd3, 32'hAAAA,     "R11"},
    '{OP_W, 3'd0, 32'h05,       3'd0, 32'h15,       "R2"},
    '{OP_W, 3'd3, 32'h1234,     3'd3, 32'hAAAA,     "R11"},
    '{OP_W, 3'd4, 32'h33,       3'd4, 32'h33,       "R11"},
    '{OP_W, 3'd2, 32'h10,       3'd2, 32'hFE,       "R5"},
    '{OP_T, 3'd0, 32'h0,        3'd0, 32'h25,       "R7"},
    '{OP_I, 3'd0, 32'h0,        3'd2, 32'hFF,       "R6"},
    '{OP_T, 3'd0, 32'h0,        3'd1, 32'h101,      "R6"},
    '{OP_I, 3'd0, 32'h0,        3'd2, 32'h00,       "R6"},
    '{OP_P, 3'd0, 32'h0,        3'd0, 32'h05,       "R7"},
    '{OP_W, 3'd0, 32'h45,       3'd0, 32'h45,       "R12"},
    '{OP_T, 3'd0, 32'h0,        3'd0, 32'h65,       "R7"},
    '{OP_W, 3'd0, 32'h00,       3'd0, 32'h11,       "R4"},
    '{OP_W, 3'd0, 32'h02,       3'd0, 32'h13,       "R12"},
    '{OP_T, 3'd0, 32'h0,        3'd2, 32'h02,       "R6"},
    '{OP_W, 3'd0, 32'h32,       3'd0, 32'h32,       "R4"},
    '{OP_T, 3'd0, 32'h0,        3'd0, 32'h22,       "R2"},
    '{OP_W, 3'd0, 32'h12,       3'd0, 32'h02,       "R8"},
    '{OP_W, 3'd1, 32'hDEADBEEF, 3'd1, 32'hDEADBEEF, "R5"},
    '{OP_I, 3'd0, 32'h0,        3'd4, 32'h33,       "R11"}
  };

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        tick;
  logic        pre_ripple;
  logic        irq;

  int n_chk;
  int n_fail;

  timer_access_guard i_timer_access_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .tick       (tick),
    .pre_ripple (pre_ripple),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus, then return inputs to idle after the edge
  task automatic cycle(input logic wen, input logic [2:0] a, input logic [31:0] d,
                       input logic tk, input logic pr);
    @(negedge clk);
    wr_en = wen; wr_addr = a; wr_data = d; tick = tk; pre_ripple = pr;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; pre_ripple = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a;
    #0.5;
    check(tag, rd_data, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; tick = 1'b0; pre_ripple = 1'b0;
    do_reset();
    // R1 reset state
    read_chk("R1", 3'd0, 32'h10);
    read_chk("R1", 3'd1, 32'h0);
    check("R1", {31'd0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      cycle(v.op == OP_W, v.addr, v.data, v.op == OP_T, v.op == OP_P);
      read_chk($sformatf("%s vec%0d", v.tag, i), v.cadr, v.exp);
    end

    // R1 reset from a busy, populated state
    do_reset();
    read_chk("R1", 3'd0, 32'h10);
    read_chk("R1", 3'd1, 32'h0);
    read_chk("R1", 3'd3, 32'h0);
    read_chk("R1", 3'd4, 32'h0);
    check("R1", {31'd0, irq}, 32'h0);

    cycle(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
    read_chk("R2", 3'd0, 32'h00);
    cycle(1'b1, 3'd0, 32'h41, 1'b0, 1'b0);
    read_chk("R2", 3'd0, 32'h51);
    cycle(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
    read_chk("R10", 3'd0, 32'h61);
    check("R10", {31'd0, irq}, 32'h1);
    // R9: software clear of ready together with a ripple
    cycle(1'b1, 3'd0, 32'h41, 1'b1, 1'b0);
    read_chk("R9", 3'd0, 32'h61);
    check("R9", {31'd0, irq}, 32'h1);
    // R9: pre-ripple warning together with a ripple
    cycle(1'b0, 3'd0, 32'h0, 1'b1, 1'b1);
    read_chk("R9", 3'd0, 32'h61);
    cycle(1'b1, 3'd0, 32'h41, 1'b0, 1'b0);
    read_chk("R8", 3'd0, 32'h41);
    check("R10", {31'd0, irq}, 32'h0);
    cycle(1'b0, 3'd0, 32'h0, 1'b1, 1'b0);
    check("R10", {31'd0, irq}, 32'h1);
    cycle(1'b1, 3'd0, 32'h21, 1'b0, 1'b0);
    read_chk("R10", 3'd0, 32'h21);
    check("R10", {31'd0, irq}, 32'h0);
    read_chk("R6", 3'd2, 32'h04);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule